// File: doc/BRIEF.md
# Frame-Clock-Aligned Multi-Lane Deserializer

This block receives a source-synchronous link made of several serial data lanes plus a slow frame clock, all sampled on one fast bit clock. Each lane, and the frame clock as one more lane, is shifted into a short history register. Parallel words are cut from that history once per word period. The block needs no training pattern. It compares the word cut from the frame-clock lane against a known pattern. On a mismatch it moves the cut point by one bit on every lane at once, so all lanes always share one word boundary.

The word period is a count of bit-clock cycles (word width divided by bits per clock) rather than a second clock. Downstream logic takes each word on the cycle its valid strobe is high. The lock flag tells it when the boundary has been confirmed. Capture is one bit per clock (SDR) or two bits per clock (DDR). Word widths run from 4 to 14.

Top module: `frame_deser`

## Requirements
- R1: While `rst_ni` is low, `word_o`, `word_vld_o`, `locked_o` and `slip_err_o` are all zero. The bit offset starts at zero.
- R2: Lane `l` receives its bits on `ser_i[l*BPC + b]`, where `b = 0` is the earlier bit within a clock. The frame clock arrives on `frm_i[b]` with the same ordering. In `word_o[l*WORD_W +: WORD_W]`, bit 0 holds the earliest received bit of the word. `word_o` changes only in a cycle where `word_vld_o` is high.
- R3: `word_vld_o` is a one-cycle pulse that repeats every `WORD_W/BPC` clocks. The first pulse comes one clock after reset release. It is high exactly in the cycles in which `word_o` presents a newly cut word.
- R4: Each frame-word mismatch advances the bit offset by exactly one, modulo `WORD_W`. The same offset cuts every lane.
- R5: `locked_o` rises after the frame word equals the pattern on 4 compared words in a row. It falls at the first compared mismatch, and the search then resumes.
- R6: After each offset step, the next two cut words are not compared.
- R7: `slip_err_o` is set when `WORD_W` consecutive offset steps occur with no match between them. The search keeps wrapping around. The flag clears when lock is next reached.
- R8: While locked, each data lane's word is one whole transmitted word. All lanes come from the same word index.
- R9: A 14-bit word captured two bits per clock (DDR) is supported, with the same alignment behaviour.
- R10: A match means that frame word bit `j` equals `FRAME_PAT[j]` for every `j`. The pattern is a parameter; the default for 7-bit words is `7'b1100011`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| ser_i | input | LANES*BPC | Serial data bits, BPC per lane per clock |
| frm_i | input | BPC | Sampled frame clock bits |
| word_o | output | LANES*WORD_W | Aligned parallel words, lane 0 in the low bits |
| word_vld_o | output | 1 | New-word strobe, once per word period |
| locked_o | output | 1 | Boundary confirmed on 4 consecutive frame words |
| slip_err_o | output | 1 | A full cycle of offsets found no match |

## Verification
The hardest state to reach is the error flag. The frame lane has to miss on a full round of offsets, but a healthy frame clock always matches within one round. The bench therefore forces the frame input low and holds it there until every offset has been tried, then restores it and checks that lock returns and the flag clears. Loss of lock is reached by skipping one bit on all lanes at once. This moves the true boundary, so the locked controller sees a mismatch and has to search again.

// File: rtl/fdeser_pkg.sv
package fdeser_pkg;

  // outcome of one word-period evaluation in the slip controller
  typedef enum logic [1:0] {
    EV_NONE,
    EV_SETTLE,
    EV_MATCH,
    EV_MISS
  } eval_e;

  function automatic int bits_per_clk(input bit ddr);
    return ddr ? 2 : 1;
  endfunction

endpackage

// File: rtl/fdeser_lane.sv
// One serial lane: keeps two words of history and cuts a word at an offset.
module fdeser_lane #(
  parameter int WORD_W = 7,
  parameter int BPC    = 1,
  parameter int SW     = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BPC-1:0]    bits_i,
  input  logic [SW-1:0]     slip_i,
  output logic [WORD_W-1:0] word_o
);

  localparam int HW = 2 * WORD_W;

  logic [HW-1:0] hist_q, hist_d, win;

  // newest bits enter at the top; bits_i[0] is the older of a pair
  always_comb begin
    hist_d = {bits_i, hist_q[HW-1:BPC]};
    win    = hist_q >> (WORD_W - int'(slip_i));
    word_o = win[WORD_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else         hist_q <= hist_d;
  end

endmodule

// File: rtl/fdeser_ctrl.sv
// Bit-offset search: compare frame word, step offset, settle, count matches.
module fdeser_ctrl
  import fdeser_pkg::*;
#(
  parameter int                WORD_W    = 7,
  parameter int                SW        = 3,
  parameter logic [WORD_W-1:0] FRAME_PAT = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [WORD_W-1:0] frame_word_i,
  output logic [SW-1:0]     slip_o,
  output logic              locked_o,
  output logic              err_o
);

  localparam logic [SW-1:0] SLIP_MAX = SW'(WORD_W - 1);
  localparam logic [1:0]    LOCK_AT  = 2'd3;   // fourth consecutive match
  localparam logic [1:0]    SETTLE_N = 2'd2;

  logic [SW-1:0] slip_q, slip_d, tries_q, tries_d;
  logic [1:0]    hold_q, hold_d, mcnt_q, mcnt_d;
  logic          locked_q, locked_d, err_q, err_d;
  eval_e         ev;

  always_comb begin
    if (!cap_i)                          ev = EV_NONE;
    else if (hold_q != 2'd0)             ev = EV_SETTLE;
    else if (frame_word_i == FRAME_PAT)  ev = EV_MATCH;
    else                                 ev = EV_MISS;
  end

  always_comb begin
    slip_d   = slip_q;
    tries_d  = tries_q;
    hold_d   = hold_q;
    mcnt_d   = mcnt_q;
    locked_d = locked_q;
    err_d    = err_q;
    unique case (ev)
      EV_SETTLE: hold_d = hold_q - 2'd1;
      EV_MATCH: begin
        tries_d = '0;
        if (!locked_q) begin
          if (mcnt_q == LOCK_AT) begin
            locked_d = 1'b1;
            err_d    = 1'b0;
          end else begin
            mcnt_d = mcnt_q + 2'd1;
          end
        end
      end
      EV_MISS: begin
        locked_d = 1'b0;
        mcnt_d   = 2'd0;
        hold_d   = SETTLE_N;
        slip_d   = (slip_q == SLIP_MAX) ? '0 : slip_q + 1'b1;
        if (tries_q == SLIP_MAX) begin
          err_d   = 1'b1;
          tries_d = '0;
        end else begin
          tries_d = tries_q + 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slip_q   <= '0;
      tries_q  <= '0;
      hold_q   <= 2'd0;
      mcnt_q   <= 2'd0;
      locked_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      slip_q   <= slip_d;
      tries_q  <= tries_d;
      hold_q   <= hold_d;
      mcnt_q   <= mcnt_d;
      locked_q <= locked_d;
      err_q    <= err_d;
    end
  end

  assign slip_o   = slip_q;
  assign locked_o = locked_q;
  assign err_o    = err_q;

  // R4: the offset only ever moves forward by one bit, wrapping
  assert_slip_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slip_q != $past(slip_q)) |->
      (slip_q == (($past(slip_q) == SLIP_MAX) ? '0 : $past(slip_q) + 1'b1)));

  // R6: a step always opens a two-word settle window and drops lock
  assert_settle_after_slip_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slip_q != $past(slip_q)) |-> (hold_q == SETTLE_N && !locked_q));

  // R5: lock is only taken on a captured frame word equal to the pattern
  assert_lock_on_match_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_q) |-> ($past(cap_i) && ($past(frame_word_i) == FRAME_PAT)));

  // R7: the error flag is only raised together with an offset step
  assert_err_with_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> (slip_q != $past(slip_q)));

endmodule

// File: rtl/frame_deser.sv
// Multi-lane deserializer aligned by a deserialized frame clock.
module frame_deser
  import fdeser_pkg::*;
#(
  parameter int                WORD_W    = 7,
  parameter int                LANES     = 2,
  parameter bit                DDR       = 1'b0,
  parameter logic [WORD_W-1:0] FRAME_PAT = 7'b1100011
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [LANES*(DDR?2:1)-1:0] ser_i,
  input  logic [(DDR?2:1)-1:0]       frm_i,
  output logic [LANES*WORD_W-1:0]    word_o,
  output logic                       word_vld_o,
  output logic                       locked_o,
  output logic                       slip_err_o
);

  localparam int BPC = bits_per_clk(DDR);
  localparam int CPW = WORD_W / BPC;               // clocks per word
  localparam int PW  = (CPW > 1) ? $clog2(CPW) : 1;
  localparam int SW  = $clog2(WORD_W);

  // word-period phase: the slow word clock as a clock enable
  logic [PW-1:0] ph_q, ph_d;
  logic          cap;

  always_comb begin
    cap  = (ph_q == '0);
    ph_d = (ph_q == PW'(CPW - 1)) ? '0 : ph_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= '0;
    else         ph_q <= ph_d;
  end

  // data lanes 0..LANES-1, frame-clock lane at index LANES
  logic [SW-1:0]     slip;
  logic [WORD_W-1:0] lane_word [LANES+1];

  for (genvar g = 0; g <= LANES; g++) begin : g_lane
    logic [BPC-1:0] bits;
    if (g < LANES) begin : g_data
      assign bits = ser_i[g*BPC +: BPC];
    end else begin : g_frame
      assign bits = frm_i;
    end
    fdeser_lane #(
      .WORD_W (WORD_W),
      .BPC    (BPC),
      .SW     (SW)
    ) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .bits_i (bits),
      .slip_i (slip),
      .word_o (lane_word[g])
    );
  end

  fdeser_ctrl #(
    .WORD_W    (WORD_W),
    .SW        (SW),
    .FRAME_PAT (FRAME_PAT)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cap_i        (cap),
    .frame_word_i (lane_word[LANES]),
    .slip_o       (slip),
    .locked_o     (locked_o),
    .err_o        (slip_err_o)
  );

  // output word register, loaded once per word period
  logic [LANES*WORD_W-1:0] word_q, word_d;
  logic                    vld_q, vld_d;

  always_comb begin
    word_d = word_q;
    vld_d  = cap;
    if (cap) begin
      for (int l = 0; l < LANES; l++) begin
        word_d[l*WORD_W +: WORD_W] = lane_word[l];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      vld_q  <= vld_d;
    end
  end

  assign word_o     = word_q;
  assign word_vld_o = vld_q;

  // R3: the strobe never lasts two cycles
  assert_vld_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |=> !word_vld_o);

  // R2: the presented words only change alongside the strobe
  assert_word_update_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_o != $past(word_o)) |-> word_vld_o);

endmodule

// File: tb/frame_deser_model.sv
// Behavioural reference: bit queues per lane and an integer search model.
module frame_deser_model #(
  parameter int                W     = 7,
  parameter int                LANES = 2,
  parameter int                BPC   = 1,
  parameter logic [W-1:0]      PAT   = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LANES*BPC-1:0] ser,
  input  logic [BPC-1:0]       frm,
  output logic [LANES*W-1:0]   exp_word,
  output logic                 exp_vld,
  output logic                 exp_locked,
  output logic                 exp_err
);

  localparam int CPW = W / BPC;

  bit strm [LANES+1][$];
  int ph, s, hold, m, tries;
  bit lk, er;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l <= LANES; l++) begin
        strm[l].delete();
        for (int k = 0; k < 2*W; k++) strm[l].push_back(1'b0);
      end
      ph = 0; s = 0; hold = 0; m = 0; tries = 0; lk = 0; er = 0;
      exp_word = '0; exp_vld = 0; exp_locked = 0; exp_err = 0;
    end else begin
      exp_vld = (ph == 0);
      if (ph == 0) begin
        bit ok;
        // queue index 0 is the oldest bit; window starts W-s from the oldest
        for (int l = 0; l < LANES; l++)
          for (int j = 0; j < W; j++)
            exp_word[l*W+j] = strm[l][W-s+j];
        ok = 1;
        for (int j = 0; j < W; j++)
          if (strm[LANES][W-s+j] != PAT[j]) ok = 0;
        if (hold > 0) begin
          hold--;
        end else if (ok) begin
          tries = 0;
          if (!lk) begin
            if (m == 3) begin lk = 1; er = 0; end
            else m++;
          end
        end else begin
          lk = 0; m = 0; hold = 2;
          s = (s + 1) % W;
          tries++;
          if (tries == W) begin er = 1; tries = 0; end
        end
        exp_locked = lk;
        exp_err    = er;
      end
      for (int b = 0; b < BPC; b++) begin
        for (int l = 0; l < LANES; l++) strm[l].push_back(ser[l*BPC+b]);
        strm[LANES].push_back(frm[b]);
      end
      for (int l = 0; l <= LANES; l++)
        while (strm[l].size() > 2*W) void'(strm[l].pop_front());
      ph = (ph + 1) % CPW;
    end
  end

endmodule

// File: tb/test_frame_deser.sv
module test_frame_deser;

  localparam int           WA   = 7;
  localparam int           WB   = 14;
  localparam int           L    = 2;
  localparam logic [WA-1:0] PATA = 7'b1100011;
  localparam logic [WB-1:0] PATB = 14'b11111110000000;

  logic clk = 1'b0;
  logic rst_n;
  always #5 clk = ~clk;

  logic [L-1:0]     ser_a;  logic [0:0] frm_a;
  logic [2*L-1:0]   ser_b;  logic [1:0] frm_b;
  logic [L*WA-1:0]  word_a, xword_a;
  logic [L*WB-1:0]  word_b, xword_b;
  logic vld_a, lk_a, err_a, xvld_a, xlk_a, xerr_a;
  logic vld_b, lk_b, err_b, xvld_b, xlk_b, xerr_b;

  frame_deser #(.WORD_W(WA), .LANES(L), .DDR(1'b0), .FRAME_PAT(PATA)) i_frame_deser (
    .clk_i(clk), .rst_ni(rst_n), .ser_i(ser_a), .frm_i(frm_a),
    .word_o(word_a), .word_vld_o(vld_a), .locked_o(lk_a), .slip_err_o(err_a));

  frame_deser #(.WORD_W(WB), .LANES(L), .DDR(1'b1), .FRAME_PAT(PATB)) i_frame_deser_ddr (
    .clk_i(clk), .rst_ni(rst_n), .ser_i(ser_b), .frm_i(frm_b),
    .word_o(word_b), .word_vld_o(vld_b), .locked_o(lk_b), .slip_err_o(err_b));

  frame_deser_model #(.W(WA), .LANES(L), .BPC(1), .PAT(PATA)) m_a (
    .clk(clk), .rst_n(rst_n), .ser(ser_a), .frm(frm_a),
    .exp_word(xword_a), .exp_vld(xvld_a), .exp_locked(xlk_a), .exp_err(xerr_a));

  frame_deser_model #(.W(WB), .LANES(L), .BPC(2), .PAT(PATB)) m_b (
    .clk(clk), .rst_n(rst_n), .ser(ser_b), .frm(frm_b),
    .exp_word(xword_b), .exp_vld(xvld_b), .exp_locked(xlk_b), .exp_err(xerr_b));

  int n_cmp = 0, n_bad = 0;
  int pos_a, pos_b, guard;
  bit stuck, glitch, done;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // data word k of lane l; lane 1 is always lane 0 plus 3
  function automatic bit dbit(input int n, input int l, input int w);
    int k, j, v;
    k = n / w; j = n % w; v = k*5 + l*3 + 1;
    return 1'(v >> j);
  endfunction

  task automatic drive();
    for (int l = 0; l < L; l++) ser_a[l] = rst_n ? dbit(pos_a, l, WA) : 1'b0;
    frm_a[0] = (rst_n && !stuck) ? PATA[pos_a % WA] : 1'b0;
    for (int b = 0; b < 2; b++) begin
      for (int l = 0; l < L; l++) ser_b[l*2+b] = rst_n ? dbit(pos_b+b, l, WB) : 1'b0;
      frm_b[b] = (rst_n && !stuck) ? PATB[(pos_b+b) % WB] : 1'b0;
    end
    if (rst_n) begin
      pos_a += 1; pos_b += 2;
      if (glitch) begin pos_a += 1; pos_b += 1; glitch = 0; guard = 40; end
    end
  endtask

  task automatic compare();
    chk(word_a == xword_a, "R2 R4 sdr word", word_a, xword_a);
    chk(vld_a == xvld_a, "R3 sdr strobe", vld_a, xvld_a);
    chk(lk_a == xlk_a, "R5 R6 sdr locked", lk_a, xlk_a);
    chk(err_a == xerr_a, "R7 sdr error", err_a, xerr_a);
    chk(word_b == xword_b, "R9 R2 R4 ddr word", word_b, xword_b);
    chk(vld_b == xvld_b, "R9 R3 ddr strobe", vld_b, xvld_b);
    chk(lk_b == xlk_b, "R9 R5 R6 ddr locked", lk_b, xlk_b);
    chk(err_b == xerr_b, "R9 R7 ddr error", err_b, xerr_b);
    if (guard > 0) guard--;
    else begin
      // R8: locked words are whole words of one index on both lanes
      if (lk_a && vld_a)
        chk(word_a[2*WA-1:WA] == WA'(word_a[WA-1:0] + 3), "R8 sdr lanes aligned",
            word_a[2*WA-1:WA], WA'(word_a[WA-1:0] + 3));
      if (lk_b && vld_b)
        chk(word_b[2*WB-1:WB] == WB'(word_b[WB-1:0] + 3), "R8 R9 ddr lanes aligned",
            word_b[2*WB-1:WB], WB'(word_b[WB-1:0] + 3));
    end
  endtask

  task automatic step();
    @(negedge clk);
    compare();
    drive();
  endtask

  task automatic wait_lock(input int limit);
    int c = 0;
    while (!(lk_a && lk_b) && c < limit) begin step(); c++; end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1ms;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; stuck = 0; glitch = 0; guard = 0; done = 0;
    pos_a = 3; pos_b = 5;
    drive();
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    chk(word_a == '0 && word_b == '0, "R1 words in reset", {word_b, word_a}, 0);
    chk(!vld_a && !vld_b, "R1 strobe in reset", {vld_b, vld_a}, 0);
    chk(!lk_a && !lk_b && !err_a && !err_b, "R1 flags in reset",
        {lk_b, lk_a, err_b, err_a}, 0);
    compare();
    rst_n = 1'b1;
    drive();

    // R10 R5: initial search reaches lock on the frame pattern
    wait_lock(1500);
    chk(lk_a, "R5 R10 sdr lock reached", lk_a, 1);
    chk(lk_b, "R5 R9 R10 ddr lock reached", lk_b, 1);
    repeat (60) step();

    // R5: a skipped bit moves the boundary, lock must drop and return
    glitch = 1;
    begin
      int c = 0;
      bit saw_a = 0, saw_b = 0;
      while (c < 200 && !(saw_a && saw_b)) begin
        step(); c++;
        if (!lk_a) saw_a = 1;
        if (!lk_b) saw_b = 1;
      end
      chk(saw_a, "R5 sdr lock lost after shift", saw_a, 1);
      chk(saw_b, "R5 R9 ddr lock lost after shift", saw_b, 1);
    end
    wait_lock(1500);
    chk(lk_a && lk_b, "R5 relock after shift", {lk_b, lk_a}, 3);
    repeat (40) step();

    // R7: dead frame clock, every offset tried, error raised
    stuck = 1; guard = 40;
    repeat (400) step();
    chk(err_a, "R7 sdr error after full round", err_a, 1);
    chk(err_b, "R7 R9 ddr error after full round", err_b, 1);
    chk(!lk_a && !lk_b, "R5 no lock on dead frame", {lk_b, lk_a}, 0);
    stuck = 0; guard = 40;
    wait_lock(1500);
    chk(lk_a && lk_b, "R7 relock after frame returns", {lk_b, lk_a}, 3);
    chk(!err_a && !err_b, "R7 error cleared on lock", {err_b, err_a}, 0);
    repeat (60) step();
    finish_run();
  end

endmodule